// File: doc/BRIEF.md
# Nonvolatile-Memory Controller Reset-Load Sequencer

This block brings a nonvolatile-memory controller out of reset. When reset is released it reads four configuration words from the storage array, in a fixed order, through a simple read port. The words are the program-area protection, the data-area protection, the option byte and the security byte. It holds them in shadow registers and, once every read is done and the buffer RAM has been initialised, commits them to the visible configuration outputs in one step. A double-bit fault on any read, or a failed buffer-RAM initialisation, makes the block commit built-in defaults instead: every bit set, so the memory is fully protected and secured. The same faults set status flags.

While the load runs, the block holds the CPU off for the first reads and then lets reads proceed. The command-complete flag stays low until the load has finished. Writes to the command index register and the two command data registers only take effect while that flag is high.

A small command runner gives commands their busy time. It can clear the secured state when an all-blocks erase-verify passes in special single-chip mode. Reset aborts a running command at once.

Top module: `nvm_boot_loader`

## Requirements
- R1: `ccif` is low from reset until the load completes. It rises on the 13th rising edge after reset is released: four reads of 3 cycles each, plus one buffer-initialisation cycle.
- R2: `cpu_hold` is high for the first 2 reads (6 cycles after release) and low afterwards. `rd_req` stays high while the remaining reads continue.
- R3: Reads use addresses `CFG_BASE+0` to `CFG_BASE+3`, in that order, each held for 3 cycles. The words read go, in order, to `prot_p`, `prot_d`, `opt_byte` and `sec_byte`.
- R4: A write with `cmd_wr_en` is ignored while `ccif` is low and takes effect while it is high. `cmd_wr_sel` selects the target: 0 is the index (low 3 bits), 1 is the high byte, 2 is the low byte.
- R5: `mgstat` reads 2'b11 if `rd_dbe` was high on the final cycle of any read, and 2'b00 otherwise.
- R6: A double-bit fault or `buf_err` makes `prot_p`, `prot_d`, `opt_byte` and `sec_byte` all read 8'hFF after the load.
- R7: `rd_sbe` on its own changes nothing: the words read are loaded and `mgstat` stays 2'b00.
- R8: `buf_err`, sampled in the buffer-initialisation cycle, sets `accerr`; `mgstat` is not affected.
- R9: `secured` is low only when `sec_byte[1:0]` is 2'b10, or after the unsecure event of R12.
- R10: `cmd_go` while `ccif` is high makes `cmd_busy` high and `ccif` low for exactly 4 cycles. `cmd_go` is ignored while `ccif` is low, and so is a write made while busy.
- R11: Reset clears `cmd_busy` and `ccif` at once, abandons any running command without applying its effect, and restarts the load.
- R12: When a command with high byte 8'h01 (verify all blocks) completes with `spec_mode` and `verify_ok` high, `secured` goes low until the next reset. It has no such effect otherwise.
- R13: A command with high byte 8'h0C (verify backdoor key), like any command, leaves `prot_p` and `prot_d` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | output | 1 | Array read in progress |
| rd_addr | output | 8 | Array read address |
| rd_data | input | 8 | Array read data |
| rd_sbe | input | 1 | Corrected single-bit fault on the current read |
| rd_dbe | input | 1 | Double-bit fault on the current read |
| buf_err | input | 1 | Buffer-RAM initialisation failed |
| cpu_hold | output | 1 | Holds off CPU accesses |
| ccif | output | 1 | Command-complete flag |
| mgstat | output | 2 | Double-bit fault status |
| accerr | output | 1 | Access-error status |
| prot_p | output | 8 | Program-area protection |
| prot_d | output | 8 | Data-area protection |
| opt_byte | output | 8 | Option byte |
| sec_byte | output | 8 | Security byte |
| secured | output | 1 | Device secured |
| cmd_wr_en | input | 1 | Command register write strobe |
| cmd_wr_sel | input | 2 | Command register select |
| cmd_wr_data | input | 8 | Command register write data |
| cmd_go | input | 1 | Launch command |
| spec_mode | input | 1 | Special single-chip mode |
| verify_ok | input | 1 | Erase-verify outcome |
| cmd_idx | output | 3 | Command index register |
| cmd_hi | output | 8 | Command high byte (opcode) |
| cmd_lo | output | 8 | Command low byte |
| cmd_busy | output | 1 | Command running |

## Verification
Reset is released on a falling edge. From there the bench counts rising edges and samples on each falling edge. `cpu_hold` must drop after the 6th edge. Each `rd_addr` must belong to read number edge/3. `ccif`, the configuration outputs and the status bits must all change after the 13th edge. A command launched before an edge must show `ccif` low at the next 4 samples and high at the 5th, and its unsecure effect appears at that 5th sample. Stimulus made during the load or while a command is busy is judged only at these points, against expected values that bench functions derive from the array contents and fault settings.

// File: rtl/nvm_boot_pkg.sv
package nvm_boot_pkg;
   localparam int CFG_WORDS = 4;
   localparam int W_PROT_P  = 0;
   localparam int W_PROT_D  = 1;
   localparam int W_OPT     = 2;
   localparam int W_SEC     = 3;

   typedef enum logic [1:0] {
      ST_FETCH = 2'd0,
      ST_BUF   = 2'd1,
      ST_DONE  = 2'd2
   } load_st_e;

   localparam logic [1:0] SEL_IDX = 2'd0;
   localparam logic [1:0] SEL_HI  = 2'd1;
   localparam logic [1:0] SEL_LO  = 2'd2;

   localparam logic [1:0] SEC_OPEN = 2'b10;

   localparam logic [7:0] OP_VERIFY_ALL = 8'h01;
   localparam logic [7:0] OP_ERASE_ALL  = 8'h08;
   localparam logic [7:0] OP_VERIFY_KEY = 8'h0C;
endpackage

// File: rtl/nvm_cfg_fetch.sv
module nvm_cfg_fetch
   import nvm_boot_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int READ_CYC = 3,
   parameter int HOLD_READS = 2,
   parameter logic [ADDR_W-1:0] CFG_BASE = 8'hF0,
   localparam int IW = $clog2(CFG_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              capture,
   output logic [IW-1:0]     cap_idx,
   output logic              buf_phase,
   output logic              load_done,
   output logic              cpu_hold
);
   localparam int CW = (READ_CYC > 1) ? $clog2(READ_CYC) : 1;

   if (READ_CYC < 1) begin : g_chk_rc
      $error("READ_CYC must be at least 1");
   end
   if (HOLD_READS > CFG_WORDS) begin : g_chk_hr
      $error("HOLD_READS exceeds the number of configuration words");
   end

   load_st_e      st_q;
   logic [IW-1:0] idx_q;
   logic [CW-1:0] cyc_q;
   logic          last_cyc, last_word;

   assign last_cyc  = (cyc_q == CW'(READ_CYC - 1));
   assign last_word = (idx_q == IW'(CFG_WORDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_FETCH;
         idx_q <= '0;
         cyc_q <= '0;
      end else begin
         case (st_q)
            ST_FETCH: begin
               if (last_cyc) begin
                  cyc_q <= '0;
                  if (last_word) st_q <= ST_BUF;
                  else           idx_q <= idx_q + 1'b1;
               end else begin
                  cyc_q <= cyc_q + 1'b1;
               end
            end
            ST_BUF:  st_q <= ST_DONE;
            default: st_q <= ST_DONE;
         endcase
      end
   end

   assign rd_req    = (st_q == ST_FETCH);
   assign rd_addr   = CFG_BASE + ADDR_W'(idx_q);
   assign capture   = rd_req && last_cyc;
   assign cap_idx   = idx_q;
   assign buf_phase = (st_q == ST_BUF);
   assign load_done = (st_q == ST_DONE);

   if (HOLD_READS == 0) begin : g_nohold
      assign cpu_hold = 1'b0;
   end else begin : g_hold
      assign cpu_hold = rd_req && (int'(idx_q) < HOLD_READS);
      if (HOLD_READS < CFG_WORDS) begin : g_release
         // R2: reads carry on after the hold is released
         p_read_after_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(cpu_hold) |-> rd_req);
      end
   end

   // R3: addresses stay inside the configuration window
   p_addr_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (int'(rd_addr - CFG_BASE) < CFG_WORDS));

   // R1: once finished, the load stays finished until reset
   p_done_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |=> load_done);
endmodule

// File: rtl/nvm_cfg_bank.sv
module nvm_cfg_bank
   import nvm_boot_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int IW = $clog2(CFG_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [IW-1:0]     cap_idx,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              rd_sbe,
   input  logic              rd_dbe,
   input  logic              buf_phase,
   input  logic              buf_err,
   output logic [DATA_W-1:0] prot_p,
   output logic [DATA_W-1:0] prot_d,
   output logic [DATA_W-1:0] opt_byte,
   output logic [DATA_W-1:0] sec_byte,
   output logic [1:0]        mgstat,
   output logic              accerr
);
   if (DATA_W < 8) begin : g_chk_dw
      $error("DATA_W must be at least 8");
   end

   logic dbe_seen_q;
   logic committed_q;
   logic fallback;

   for (genvar g = 0; g < CFG_WORDS; g++) begin : g_shadow
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) word_q <= '1;
         else if (capture && (cap_idx == IW'(g))) word_q <= rd_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dbe_seen_q <= 1'b0;
      else if (capture && rd_dbe) dbe_seen_q <= 1'b1;
   end

   assign fallback = dbe_seen_q || buf_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot_p      <= '1;
         prot_d      <= '1;
         opt_byte    <= '1;
         sec_byte    <= '1;
         mgstat      <= 2'b00;
         accerr      <= 1'b0;
         committed_q <= 1'b0;
      end else if (buf_phase && !committed_q) begin
         committed_q <= 1'b1;
         mgstat      <= {2{dbe_seen_q}};
         accerr      <= buf_err;
         if (fallback) begin
            prot_p   <= '1;
            prot_d   <= '1;
            opt_byte <= '1;
            sec_byte <= '1;
         end else begin
            prot_p   <= g_shadow[W_PROT_P].word_q;
            prot_d   <= g_shadow[W_PROT_D].word_q;
            opt_byte <= g_shadow[W_OPT].word_q;
            sec_byte <= g_shadow[W_SEC].word_q;
         end
      end
   end

   // R5: both fault bits move together
   p_mgstat_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mgstat[0] == mgstat[1]);

   // R6: any reported error goes with full-protection defaults
   p_fallback_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mgstat != 2'b00 || accerr) |->
         (prot_p == '1 && prot_d == '1 && opt_byte == '1 && sec_byte == '1));

   // R7: a corrected fault alone does not mark the load as faulty
   p_sbe_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && rd_sbe && !rd_dbe && !dbe_seen_q) |=> !dbe_seen_q);

   // R13: protection is frozen once committed
   p_prot_frozen_r13: assert property (@(posedge clk) disable iff (!rst_n)
      committed_q |=> ($stable(prot_p) && $stable(prot_d)));
endmodule

// File: rtl/nvm_cmd_gate.sv
module nvm_cmd_gate
   import nvm_boot_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int IDX_W = 3,
   parameter int CMD_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_done,
   input  logic              cmd_wr_en,
   input  logic [1:0]        cmd_wr_sel,
   input  logic [DATA_W-1:0] cmd_wr_data,
   input  logic              cmd_go,
   input  logic              spec_mode,
   input  logic              verify_ok,
   output logic [IDX_W-1:0]  cmd_idx,
   output logic [DATA_W-1:0] cmd_hi,
   output logic [DATA_W-1:0] cmd_lo,
   output logic              cmd_busy,
   output logic              ccif,
   output logic              unsec
);
   localparam int KW = (CMD_CYC > 1) ? $clog2(CMD_CYC) : 1;

   if (CMD_CYC < 1) begin : g_chk_cc
      $error("CMD_CYC must be at least 1");
   end
   if (IDX_W > DATA_W) begin : g_chk_iw
      $error("IDX_W must not exceed DATA_W");
   end

   logic busy_q, run_last, start;

   assign ccif     = load_done && !busy_q;
   assign start    = ccif && cmd_go;
   assign cmd_busy = busy_q;

   if (CMD_CYC == 1) begin : g_single
      assign run_last = 1'b1;
   end else begin : g_count
      logic [KW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cnt_q <= '0;
         else if (start) cnt_q <= KW'(CMD_CYC - 1);
         else if (busy_q && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
      assign run_last = (cnt_q == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         unsec  <= 1'b0;
      end else begin
         if (start) busy_q <= 1'b1;
         else if (busy_q && run_last) begin
            busy_q <= 1'b0;
            if (cmd_hi == DATA_W'(OP_VERIFY_ALL) && spec_mode && verify_ok)
               unsec <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_idx <= '0;
         cmd_hi  <= '0;
         cmd_lo  <= '0;
      end else if (ccif && cmd_wr_en) begin
         case (cmd_wr_sel)
            SEL_IDX: cmd_idx <= cmd_wr_data[IDX_W-1:0];
            SEL_HI:  cmd_hi  <= cmd_wr_data;
            SEL_LO:  cmd_lo  <= cmd_wr_data;
            default: ;
         endcase
      end
   end

   // R4: writes with the completion flag low leave the registers alone
   p_write_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ccif && cmd_wr_en) |=> ($stable(cmd_idx) && $stable(cmd_hi) && $stable(cmd_lo)));

   // R10: a command starts only from an accepted launch
   p_go_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(load_done && cmd_go));

   // R12: unsecuring needs special mode and a passing verify
   p_unsec_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unsec) |-> $past(busy_q && spec_mode && verify_ok));
endmodule

// File: rtl/nvm_boot_loader.sv
module nvm_boot_loader
   import nvm_boot_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int IDX_W = 3,
   parameter int READ_CYC = 3,
   parameter int HOLD_READS = 2,
   parameter int CMD_CYC = 4,
   parameter logic [ADDR_W-1:0] CFG_BASE = 8'hF0
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              rd_sbe,
   input  logic              rd_dbe,
   input  logic              buf_err,
   output logic              cpu_hold,
   output logic              ccif,
   output logic [1:0]        mgstat,
   output logic              accerr,
   output logic [DATA_W-1:0] prot_p,
   output logic [DATA_W-1:0] prot_d,
   output logic [DATA_W-1:0] opt_byte,
   output logic [DATA_W-1:0] sec_byte,
   output logic              secured,
   input  logic              cmd_wr_en,
   input  logic [1:0]        cmd_wr_sel,
   input  logic [DATA_W-1:0] cmd_wr_data,
   input  logic              cmd_go,
   input  logic              spec_mode,
   input  logic              verify_ok,
   output logic [IDX_W-1:0]  cmd_idx,
   output logic [DATA_W-1:0] cmd_hi,
   output logic [DATA_W-1:0] cmd_lo,
   output logic              cmd_busy
);
   localparam int IW = $clog2(CFG_WORDS);

   logic          capture, buf_phase, load_done, unsec;
   logic [IW-1:0] cap_idx;

   nvm_cfg_fetch #(
      .ADDR_W(ADDR_W), .READ_CYC(READ_CYC),
      .HOLD_READS(HOLD_READS), .CFG_BASE(CFG_BASE)
   ) u_fetch (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
      .capture(capture), .cap_idx(cap_idx), .buf_phase(buf_phase),
      .load_done(load_done), .cpu_hold(cpu_hold)
   );

   nvm_cfg_bank #(.DATA_W(DATA_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .capture(capture), .cap_idx(cap_idx),
      .rd_data(rd_data), .rd_sbe(rd_sbe), .rd_dbe(rd_dbe),
      .buf_phase(buf_phase), .buf_err(buf_err),
      .prot_p(prot_p), .prot_d(prot_d), .opt_byte(opt_byte),
      .sec_byte(sec_byte), .mgstat(mgstat), .accerr(accerr)
   );

   nvm_cmd_gate #(.DATA_W(DATA_W), .IDX_W(IDX_W), .CMD_CYC(CMD_CYC)) u_gate (
      .clk(clk), .rst_n(rst_n), .load_done(load_done),
      .cmd_wr_en(cmd_wr_en), .cmd_wr_sel(cmd_wr_sel), .cmd_wr_data(cmd_wr_data),
      .cmd_go(cmd_go), .spec_mode(spec_mode), .verify_ok(verify_ok),
      .cmd_idx(cmd_idx), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
      .cmd_busy(cmd_busy), .ccif(ccif), .unsec(unsec)
   );

   assign secured = (sec_byte[1:0] != SEC_OPEN) && !unsec;

   // R1: completion flag low until the load has finished
   p_ccif_wait_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !load_done |-> !ccif);

   // R9: an error fallback always leaves the device secured unless unsecured later
   p_secure_fallback_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((mgstat != 2'b00 || accerr) && !unsec) |-> secured);

   // R11: immediately after reset no command is running
   p_abort_r11: assert property (@(posedge clk)
      $rose(rst_n) |-> !cmd_busy);
endmodule

// File: tb/nvm_boot_loader_test.sv
`timescale 1ns/1ps
module nvm_boot_loader_test;
   localparam int RC = 3, HR = 2, CC = 4, NW = 4;
   localparam int LOAD = NW * RC + 1;
   localparam logic [7:0] BASE = 8'hF0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rd_req, rd_sbe, rd_dbe, buf_err, cpu_hold, ccif, accerr, secured;
   logic [7:0] rd_addr, rd_data, prot_p, prot_d, opt_byte, sec_byte, cmd_hi, cmd_lo, cmd_wr_data;
   logic [1:0] mgstat, cmd_wr_sel;
   logic [2:0] cmd_idx;
   logic cmd_wr_en = 1'b0, cmd_go = 1'b0, spec_mode = 1'b0, verify_ok = 1'b0, cmd_busy;

   logic [7:0] mem [NW];
   bit   dbe_on, sbe_on;
   int   dbe_word;
   logic [7:0] off;

   int total = 0, bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   assign off = rd_addr - BASE;
   always_comb begin
      rd_data = 8'h00;
      rd_dbe  = 1'b0;
      rd_sbe  = 1'b0;
      if (rd_req) begin
         rd_data = mem[off[1:0]];
         rd_dbe  = dbe_on && (int'(off) == dbe_word);
         rd_sbe  = sbe_on;
      end
   end

   nvm_boot_loader uut (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
      .rd_sbe(rd_sbe), .rd_dbe(rd_dbe), .buf_err(buf_err), .cpu_hold(cpu_hold),
      .ccif(ccif), .mgstat(mgstat), .accerr(accerr), .prot_p(prot_p), .prot_d(prot_d),
      .opt_byte(opt_byte), .sec_byte(sec_byte), .secured(secured),
      .cmd_wr_en(cmd_wr_en), .cmd_wr_sel(cmd_wr_sel), .cmd_wr_data(cmd_wr_data),
      .cmd_go(cmd_go), .spec_mode(spec_mode), .verify_ok(verify_ok),
      .cmd_idx(cmd_idx), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo), .cmd_busy(cmd_busy)
   );

   task automatic chk(string req, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic bit exp_fb();
      return dbe_on || buf_err;
   endfunction

   function automatic int exp_word(int i);
      return exp_fb() ? 8'hFF : int'(mem[i]);
   endfunction

   function automatic int exp_secured();
      return (exp_fb() || mem[3][1:0] != 2'b10) ? 1 : 0;
   endfunction

   task automatic do_load();
      rst_n = 1'b0;
      #1;
      chk("R11", "busy in reset", int'(cmd_busy), 0);
      chk("R11", "ccif in reset", int'(ccif), 0);
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk("R2", "hold at release", int'(cpu_hold), 1);
      for (int k = 1; k <= LOAD; k++) begin
         if (k == 2) begin
            cmd_wr_en = 1'b1; cmd_wr_sel = 2'd1; cmd_wr_data = 8'hAA;
         end
         if (k == 4) cmd_go = 1'b1;
         @(negedge clk);
         cmd_wr_en = 1'b0;
         cmd_go    = 1'b0;
         chk("R1", $sformatf("ccif at edge %0d", k), int'(ccif), (k == LOAD) ? 1 : 0);
         chk("R2", $sformatf("hold at edge %0d", k), int'(cpu_hold), (k < HR * RC) ? 1 : 0);
         if (k < NW * RC) begin
            chk("R2", $sformatf("rd_req at edge %0d", k), int'(rd_req), 1);
            chk("R3", $sformatf("addr at edge %0d", k), int'(rd_addr), int'(BASE) + k / RC);
         end
      end
      chk("R4", "write during load ignored", int'(cmd_hi), 0);
      chk("R10", "go during load ignored", int'(cmd_busy), 0);
      chk("R6", "prot_p", int'(prot_p), exp_word(0));
      chk("R3", "prot_d", int'(prot_d), exp_word(1));
      chk("R3", "opt_byte", int'(opt_byte), exp_word(2));
      chk("R6", "sec_byte", int'(sec_byte), exp_word(3));
      chk("R5", "mgstat", int'(mgstat), dbe_on ? 3 : 0);
      chk("R8", "accerr", int'(accerr), int'(buf_err));
      chk("R9", "secured", int'(secured), exp_secured());
   endtask

   task automatic wr(logic [1:0] sel, logic [7:0] d);
      cmd_wr_en = 1'b1; cmd_wr_sel = sel; cmd_wr_data = d;
      @(negedge clk);
      cmd_wr_en = 1'b0;
   endtask

   task automatic run_cmd(logic [7:0] op, bit sm, bit vok);
      logic [7:0] lo_before;
      wr(2'd1, op);
      lo_before = cmd_lo;
      spec_mode = sm; verify_ok = vok; cmd_go = 1'b1;
      @(negedge clk);
      cmd_go = 1'b0;
      for (int j = 1; j <= CC; j++) begin
         chk("R10", $sformatf("ccif busy cycle %0d", j), int'(ccif), 0);
         chk("R10", $sformatf("busy cycle %0d", j), int'(cmd_busy), 1);
         if (j == 2) begin
            cmd_wr_en = 1'b1; cmd_wr_sel = 2'd2; cmd_wr_data = ~lo_before;
         end
         @(negedge clk);
         cmd_wr_en = 1'b0;
      end
      chk("R10", "ccif after command", int'(ccif), 1);
      chk("R4", "write while busy ignored", int'(cmd_lo), int'(lo_before));
      spec_mode = 1'b0; verify_ok = 1'b0;
   endtask

   initial begin
      #800000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] pp, pd;
      void'($urandom(32'h5EED));
      cmd_wr_sel = 2'd0; cmd_wr_data = 8'h00;
      buf_err = 1'b0; dbe_on = 0; sbe_on = 0; dbe_word = 0;

      // clean load, open security byte
      mem[0] = 8'h3A; mem[1] = 8'h5C; mem[2] = 8'hA5; mem[3] = 8'hE2;
      do_load();
      wr(2'd0, 8'h05);
      chk("R4", "index write", int'(cmd_idx), 5);
      wr(2'd2, 8'h77);
      chk("R4", "low byte write", int'(cmd_lo), 8'h77);

      // secured byte, then commands
      mem[3] = 8'hF1;
      do_load();
      pp = prot_p; pd = prot_d;
      run_cmd(8'h0C, 1'b1, 1'b1);
      chk("R13", "prot_p after key verify", int'(prot_p), int'(pp));
      chk("R13", "prot_d after key verify", int'(prot_d), int'(pd));
      chk("R13", "secured after key verify", int'(secured), 1);
      run_cmd(8'h01, 1'b0, 1'b1);
      chk("R12", "no unsecure outside special mode", int'(secured), 1);
      run_cmd(8'h01, 1'b1, 1'b0);
      chk("R12", "no unsecure on failed verify", int'(secured), 1);
      run_cmd(8'h08, 1'b1, 1'b1);
      chk("R12", "erase-all alone keeps secured", int'(secured), 1);
      run_cmd(8'h01, 1'b1, 1'b1);
      chk("R12", "unsecured after verify in special mode", int'(secured), 0);
      chk("R13", "prot_p after verify", int'(prot_p), int'(pp));

      // abort a verify mid-run
      wr(2'd1, 8'h01);
      spec_mode = 1'b1; verify_ok = 1'b1; cmd_go = 1'b1;
      @(negedge clk);
      cmd_go = 1'b0;
      @(negedge clk);
      do_load();
      chk("R11", "aborted verify leaves secured", int'(secured), 1);
      spec_mode = 1'b0; verify_ok = 1'b0;

      // directed faults
      dbe_on = 1; dbe_word = 0; do_load();
      dbe_word = 3; do_load();
      dbe_on = 0; buf_err = 1'b1; do_load();
      buf_err = 1'b0; sbe_on = 1; mem[3] = 8'h12; do_load();
      chk("R7", "sbe keeps open state", int'(secured), 0);
      sbe_on = 0;

      // constrained random loads
      for (int r = 0; r < 10; r++) begin
         for (int i = 0; i < NW; i++) mem[i] = 8'($urandom);
         if ($urandom % 2 == 0) mem[3][1:0] = 2'b10;
         dbe_on   = ($urandom % 3 == 0);
         dbe_word = int'($urandom % NW);
         sbe_on   = ($urandom % 2 == 0);
         buf_err  = ($urandom % 4 == 0);
         do_load();
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule